// File: doc/BRIEF.md
# Deferred Condition-Code Evaluator

This block holds processor condition codes in lazy form. The ALU does not compute five flag bits after every instruction. It hands over an operation tag and up to three raw words. The evaluator keeps them and rebuilds the extend, negative, zero, overflow and carry flags only when they are needed. For add and subtract, the rebuild works backwards from the stored result and the second operand. The first operand is recovered by the inverse operation and then sign-extended to the operand size. For compare, both operands are stored and the difference is formed on the spot.

The packed 5-bit flag word is always visible on `flags_o` and is driven from the stored state. A flag byte can also be written directly. A flush command rewrites the stored state into the explicit-flags form without changing the visible flags, so later reads need no reconstruction. Commands are encoded on `cmd_i`: 0 idle, 1 record, 2 load flag byte, 3 flush. The parameter `W` (default 32, must exceed 16) is the long-operand width.

Top module: `ccr_eval`

## Requirements
- R1: After reset the stored tag is 0 (explicit flags), x/n/v/c are zero, the z word is 1, `err_o` is 0 and `flags_o` is 5'b00000.
- R2: A record command (1) with a known tag stores `tag_i`, `x_i`, `n_i`, `z_i`, `v_i` and `c_i`, which appear on the state outputs one cycle later.
- R3: `flags_o` packs X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Under tag 0 (explicit flags), X=x, N=n[W-1], Z=(z==0), V=v[W-1] and C=c.
- R4: Tags 1/2/3 are add in byte/word/long size. n holds the sign-extended result, v holds the sign-extended second operand, and x holds the carry. The flags equal those of the add: X=C=x, N=result sign, Z=(result==0), V=signed overflow.
- R5: Tags 4/5/6 are subtract in byte/word/long size, using the same storage as R4 with x holding the borrow. V is the signed overflow of the subtraction.
- R6: Tags 7/8/9 are compare in byte/word/long size. n and v hold the sign-extended operands. X passes x, N and Z come from the size-extended difference, V is its signed overflow, and C is set when n is below v unsigned.
- R7: Tag 10 is logic: X=x, N=n[W-1], Z=(n==0), and V and C are both 0, whatever v, z and c hold.
- R8: A load command (2) sets tag 0, x=ccr_i[4], c=ccr_i[0], n and v to all-ones or zero from ccr_i[3] and ccr_i[1], and z to 0 when ccr_i[2] is set and 1 otherwise. As a result, `flags_o` equals `ccr_i` one cycle later.
- R9: A flush command (3) sets the tag to 0 and stores the rebuilt words, leaving `flags_o` unchanged.
- R10: A record with a tag of 11 to 15 leaves the stored state unchanged and raises `err_o` for exactly the following cycle. `err_o` is never high otherwise.
- R11: An idle command (0) leaves the stored state unchanged whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 0 idle, 1 record, 2 load flags, 3 flush |
| tag_i | input | 4 | Operation tag for record |
| x_i | input | 1 | Extend/carry bit for record |
| n_i | input | W | Result or first operand word |
| z_i | input | W | Zero word (explicit-flags tag only) |
| v_i | input | W | Second operand or overflow word |
| c_i | input | 1 | Carry bit (explicit-flags tag only) |
| ccr_i | input | 5 | Flag byte for load |
| flags_o | output | 5 | Packed flags {X,N,Z,V,C} |
| tag_o | output | 4 | Stored tag |
| x_o | output | 1 | Stored x |
| n_o | output | W | Stored n word |
| z_o | output | W | Stored z word |
| v_o | output | W | Stored v word |
| c_o | output | 1 | Stored c |
| err_o | output | 1 | Unknown-tag record in previous cycle |

## Verification
The properties assume that the recorder supplies words already sign-extended to the operand size. They also assume that `cmd_i` and the data inputs are steady around each rising edge. Only under the first assumption do the rebuilt operands match the originals. The stimulus honours both assumptions. It drives inputs on the falling edge, and it builds every record's n and v from masked operands sign-extended in the bench. It sweeps byte operands on a dense grid and word and long operands from a pseudo-random stream mixed with sign-boundary corners. It also covers all 32 flag bytes and every unknown tag.

// File: rtl/ccr_eval_pkg.sv
package ccr_eval_pkg;

    typedef enum logic [3:0] {
        TAG_FLAGS = 4'd0,
        TAG_ADDB  = 4'd1,
        TAG_ADDW  = 4'd2,
        TAG_ADDL  = 4'd3,
        TAG_SUBB  = 4'd4,
        TAG_SUBW  = 4'd5,
        TAG_SUBL  = 4'd6,
        TAG_CMPB  = 4'd7,
        TAG_CMPW  = 4'd8,
        TAG_CMPL  = 4'd9,
        TAG_LOGIC = 4'd10
    } tag_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_REC   = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_FLUSH = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        KIND_PASS  = 2'd0,
        KIND_ADD   = 2'd1,
        KIND_SUB   = 2'd2,
        KIND_CMP   = 2'd3
    } kind_e;

    localparam int unsigned FLAG_BITS = 5;
    localparam int unsigned BIT_X = 4;
    localparam int unsigned BIT_N = 3;
    localparam int unsigned BIT_Z = 2;
    localparam int unsigned BIT_V = 1;
    localparam int unsigned BIT_C = 0;

    function automatic logic tag_known(input logic [3:0] t);
        return t <= TAG_LOGIC;
    endfunction

endpackage

// File: rtl/ccr_eval_decode.sv
module ccr_eval_decode
    import ccr_eval_pkg::*;
(
    input  logic [3:0] tag_i,
    output kind_e      kind_o,
    output logic [1:0] size_o,
    output logic       logic_o
);
    always_comb begin
        kind_o  = KIND_PASS;
        size_o  = 2'd2;
        logic_o = 1'b0;
        if (tag_i >= TAG_ADDB && tag_i <= TAG_ADDL) begin
            kind_o = KIND_ADD;
            size_o = 2'(tag_i - TAG_ADDB);
        end else if (tag_i >= TAG_SUBB && tag_i <= TAG_SUBL) begin
            kind_o = KIND_SUB;
            size_o = 2'(tag_i - TAG_SUBB);
        end else if (tag_i >= TAG_CMPB && tag_i <= TAG_CMPL) begin
            kind_o = KIND_CMP;
            size_o = 2'(tag_i - TAG_CMPB);
        end else if (tag_i == TAG_LOGIC) begin
            logic_o = 1'b1;
        end
    end
endmodule

// File: rtl/ccr_eval_resolve.sv
module ccr_eval_resolve
    import ccr_eval_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [3:0]   tag_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] z_i,
    input  logic [W-1:0] v_i,
    input  logic         x_i,
    input  logic         c_i,
    output logic [W-1:0] n_o,
    output logic [W-1:0] z_o,
    output logic [W-1:0] v_o,
    output logic         c_o
);
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    kind_e      kind;
    logic [1:0] size;
    logic       is_logic;

    ccr_eval_decode u_dec (
        .tag_i  (tag_i),
        .kind_o (kind),
        .size_o (size),
        .logic_o(is_logic)
    );

    function automatic logic [W-1:0] widen(input logic [W-1:0] a, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
            2'd1:    return {{(W-WORD_W){a[WORD_W-1]}}, a[WORD_W-1:0]};
            default: return a;
        endcase
    endfunction

    logic [W-1:0] first_d;
    logic [W-1:0] diff_d;

    always_comb begin
        n_o     = n_i;
        z_o     = z_i;
        v_o     = v_i;
        c_o     = c_i;
        first_d = '0;
        diff_d  = '0;
        case (kind)
            KIND_ADD: begin
                first_d = widen(n_i - v_i, size);
                z_o     = n_i;
                c_o     = x_i;
                v_o     = (n_i ^ first_d) & ~(first_d ^ v_i);
            end
            KIND_SUB: begin
                first_d = widen(n_i + v_i, size);
                z_o     = n_i;
                c_o     = x_i;
                v_o     = (n_i ^ first_d) & (first_d ^ v_i);
            end
            KIND_CMP: begin
                diff_d = widen(n_i - v_i, size);
                n_o    = diff_d;
                z_o    = diff_d;
                c_o    = n_i < v_i;
                v_o    = (diff_d ^ n_i) & (n_i ^ v_i);
            end
            default: begin
                if (is_logic) begin
                    z_o = n_i;
                    v_o = '0;
                    c_o = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/ccr_eval_pack.sv
module ccr_eval_pack
    import ccr_eval_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                 x_i,
    input  logic [W-1:0]         n_i,
    input  logic [W-1:0]         z_i,
    input  logic [W-1:0]         v_i,
    input  logic                 c_i,
    output logic [FLAG_BITS-1:0] flags_o
);
    always_comb begin
        flags_o        = '0;
        flags_o[BIT_X] = x_i;
        flags_o[BIT_N] = n_i[W-1];
        flags_o[BIT_Z] = (z_i == '0);
        flags_o[BIT_V] = v_i[W-1];
        flags_o[BIT_C] = c_i;
    end
endmodule

// File: rtl/ccr_eval.sv
module ccr_eval
    import ccr_eval_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cmd_i,
    input  logic [3:0]           tag_i,
    input  logic                 x_i,
    input  logic [W-1:0]         n_i,
    input  logic [W-1:0]         z_i,
    input  logic [W-1:0]         v_i,
    input  logic                 c_i,
    input  logic [FLAG_BITS-1:0] ccr_i,
    output logic [FLAG_BITS-1:0] flags_o,
    output logic [3:0]           tag_o,
    output logic                 x_o,
    output logic [W-1:0]         n_o,
    output logic [W-1:0]         z_o,
    output logic [W-1:0]         v_o,
    output logic                 c_o,
    output logic                 err_o
);
    typedef struct packed {
        logic [3:0]   tag;
        logic         x;
        logic [W-1:0] n;
        logic [W-1:0] z;
        logic [W-1:0] v;
        logic         c;
        logic         err;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] rn, rz, rv;
    logic         rc;

    ccr_eval_resolve #(.W(W)) u_resolve (
        .tag_i(st_q.tag),
        .n_i  (st_q.n),
        .z_i  (st_q.z),
        .v_i  (st_q.v),
        .x_i  (st_q.x),
        .c_i  (st_q.c),
        .n_o  (rn),
        .z_o  (rz),
        .v_o  (rv),
        .c_o  (rc)
    );

    ccr_eval_pack #(.W(W)) u_pack (
        .x_i    (st_q.x),
        .n_i    (rn),
        .z_i    (rz),
        .v_i    (rv),
        .c_i    (rc),
        .flags_o(flags_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (cmd_i)
            CMD_REC: begin
                if (tag_known(tag_i)) begin
                    st_d.tag = tag_i;
                    st_d.x   = x_i;
                    st_d.n   = n_i;
                    st_d.z   = z_i;
                    st_d.v   = v_i;
                    st_d.c   = c_i;
                end else begin
                    st_d.err = 1'b1;
                end
            end
            CMD_LOAD: begin
                st_d.tag = TAG_FLAGS;
                st_d.x   = ccr_i[BIT_X];
                st_d.n   = {W{ccr_i[BIT_N]}};
                st_d.z   = ccr_i[BIT_Z] ? '0 : W'(1);
                st_d.v   = {W{ccr_i[BIT_V]}};
                st_d.c   = ccr_i[BIT_C];
            end
            CMD_FLUSH: begin
                st_d.tag = TAG_FLAGS;
                st_d.n   = rn;
                st_d.z   = rz;
                st_d.v   = rv;
                st_d.c   = rc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tag <= TAG_FLAGS;
            st_q.z   <= W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_o = st_q.tag;
    assign x_o   = st_q.x;
    assign n_o   = st_q.n;
    assign z_o   = st_q.z;
    assign v_o   = st_q.v;
    assign c_o   = st_q.c;
    assign err_o = st_q.err;

endmodule

// File: rtl/ccr_eval_chk.sv
module ccr_eval_chk
    import ccr_eval_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cmd_i,
    input logic [3:0]           tag_i,
    input logic [FLAG_BITS-1:0] ccr_i,
    input logic [FLAG_BITS-1:0] flags_o,
    input logic [3:0]           tag_o,
    input logic                 x_o,
    input logic [W-1:0]         n_o,
    input logic [W-1:0]         z_o,
    input logic [W-1:0]         v_o,
    input logic                 c_o,
    input logic                 err_o
);
    logic bad_rec;
    assign bad_rec = (cmd_i == CMD_REC) && (tag_i > TAG_LOGIC);

    p_load_roundtrip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> (flags_o == $past(ccr_i)) && (tag_o == TAG_FLAGS));

    p_flush_same_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_FLUSH) |=> $stable(flags_o) && (tag_o == TAG_FLAGS));

    p_bad_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_rec |=> err_o && $stable(tag_o) && $stable(n_o) && $stable(z_o)
                    && $stable(v_o) && $stable(x_o) && $stable(c_o));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(bad_rec));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_IDLE) |=> $stable(tag_o) && $stable(n_o) && $stable(z_o)
                                && $stable(v_o) && $stable(x_o) && $stable(c_o));

    p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_o == TAG_LOGIC) |-> !flags_o[BIT_V] && !flags_o[BIT_C]);

    p_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tag_o <= TAG_LOGIC);

endmodule

bind ccr_eval ccr_eval_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd_i),
    .tag_i  (tag_i),
    .ccr_i  (ccr_i),
    .flags_o(flags_o),
    .tag_o  (tag_o),
    .x_o    (x_o),
    .n_o    (n_o),
    .z_o    (z_o),
    .v_o    (v_o),
    .c_o    (c_o),
    .err_o  (err_o)
);

// File: tb/ccr_eval_bench.sv
module ccr_eval_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cmd_i = 2'd0;
    logic [3:0]   tag_i = 4'd0;
    logic         x_i = 1'b0;
    logic [W-1:0] n_i = '0;
    logic [W-1:0] z_i = '0;
    logic [W-1:0] v_i = '0;
    logic         c_i = 1'b0;
    logic [4:0]   ccr_i = '0;
    logic [4:0]   flags_o;
    logic [3:0]   tag_o;
    logic         x_o;
    logic [W-1:0] n_o;
    logic [W-1:0] z_o;
    logic [W-1:0] v_o;
    logic         c_o;
    logic         err_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    ccr_eval #(.W(W)) u_ccr_eval (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .tag_i(tag_i), .x_i(x_i),
        .n_i(n_i), .z_i(z_i), .v_i(v_i), .c_i(c_i), .ccr_i(ccr_i),
        .flags_o(flags_o), .tag_o(tag_o), .x_o(x_o), .n_o(n_o), .z_o(z_o),
        .v_o(v_o), .c_o(c_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[15:0], seed[31:16]} ^ (seed >> 7);
    endfunction

    function automatic logic [31:0] sext(input logic [31:0] val, input int bits);
        logic signed [31:0] t;
        t = $signed(val << (32 - bits));
        return 32'(t >>> (32 - bits));
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rec(input logic [3:0] t, input logic [31:0] n, input logic [31:0] z,
                       input logic [31:0] v, input logic x, input logic c);
        cmd_i = 2'd1; tag_i = t; n_i = n; z_i = z; v_i = v; x_i = x; c_i = c;
        @(negedge clk);
        cmd_i = 2'd0;
    endtask

    task automatic flush_check(input string req, input logic [4:0] exp);
        cmd_i = 2'd3;
        @(negedge clk);
        cmd_i = 2'd0;
        check({req, " flush flags (R9)"}, 32'(flags_o), 32'(exp));
        check("R9 flush tag", 32'(tag_o), 32'd0);
    endtask

    // kind 0 add, 1 sub, 2 compare; szi 0 byte, 1 word, 2 long
    task automatic arith(input int kind, input int szi, input logic [31:0] ai,
                         input logic [31:0] bi, input logic xin, input logic do_flush);
        int bits;
        logic [31:0] mask, a, b, r;
        logic [63:0] full;
        logic cy, ovf, sa, sb, sr;
        logic [4:0] exp;
        string req;
        bits = (szi == 0) ? 8 : (szi == 1) ? 16 : 32;
        mask = (bits == 32) ? 32'hffff_ffff : ((32'd1 << bits) - 32'd1);
        a = ai & mask;
        b = bi & mask;
        if (kind == 0) begin
            full = 64'(a) + 64'(b);
            r = full[31:0] & mask;
            cy = full > 64'(mask);
        end else begin
            r = (a - b) & mask;
            cy = a < b;
        end
        sa = a[bits-1]; sb = b[bits-1]; sr = r[bits-1];
        if (kind == 0) ovf = (sa == sb) && (sr != sa);
        else           ovf = (sa != sb) && (sr != sa);
        if (kind == 0) begin
            req = "R4 add";
            exp = {cy, sr, r == 0, ovf, cy};
            rec(4'(1 + szi), sext(r, bits), rnd(), sext(b, bits), cy, rnd() > 32'h8000_0000);
        end else if (kind == 1) begin
            req = "R5 sub";
            exp = {cy, sr, r == 0, ovf, cy};
            rec(4'(4 + szi), sext(r, bits), rnd(), sext(b, bits), cy, rnd() > 32'h8000_0000);
        end else begin
            req = "R6 cmp";
            exp = {xin, sr, r == 0, ovf, cy};
            rec(4'(7 + szi), sext(a, bits), rnd(), sext(b, bits), xin, rnd() > 32'h8000_0000);
        end
        check(req, 32'(flags_o), 32'(exp));
        if (do_flush) flush_check(req, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        logic [4:0] prev;
        logic [3:0] prevtag;
        logic [31:0] corners [6];
        corners[0] = 32'h0000_0000; corners[1] = 32'hffff_ffff;
        corners[2] = 32'h7fff_ffff; corners[3] = 32'h8000_0000;
        corners[4] = 32'h0000_7f80; corners[5] = 32'h0000_8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", 32'(flags_o), 32'd0);
        check("R1 tag", 32'(tag_o), 32'd0);
        check("R1 z word", z_o, 32'd1);
        check("R1 err", 32'(err_o), 32'd0);

        // R2 / R3 explicit-flags record
        for (int i = 0; i < 64; i++) begin
            logic [31:0] nn, zz, vv;
            logic xx, cc;
            nn = rnd(); zz = (i % 4 == 0) ? 32'd0 : rnd(); vv = rnd();
            xx = nn[5]; cc = vv[9];
            rec(4'd0, nn, zz, vv, xx, cc);
            check("R2 n stored", n_o, nn);
            check("R2 z stored", z_o, zz);
            check("R2 v stored", v_o, vv);
            check("R2 x/c stored", {30'd0, x_o, c_o}, {30'd0, xx, cc});
            check("R3 packed", 32'(flags_o), 32'({xx, nn[31], zz == 0, vv[31], cc}));
        end

        // R4 R5 R6 byte grid
        cnt = 0;
        for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 3) begin
                for (int k = 0; k < 3; k++) begin
                    cnt++;
                    arith(k, 0, 32'(a), 32'(b), cnt[0], (cnt % 13) == 0);
                end
            end
        end
        // byte extremes
        for (int k = 0; k < 3; k++) begin
            arith(k, 0, 32'h7f, 32'h01, 1'b0, 1'b1);
            arith(k, 0, 32'h80, 32'h01, 1'b1, 1'b1);
            arith(k, 0, 32'hff, 32'hff, 1'b0, 1'b0);
            arith(k, 0, 32'h00, 32'h00, 1'b1, 1'b0);
        end
        // word and long: corners and pseudo-random
        for (int szi = 1; szi < 3; szi++) begin
            for (int k = 0; k < 3; k++) begin
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        arith(k, szi, corners[i], corners[j], 1'(i + j), 1'b1);
                for (int i = 0; i < 2000; i++)
                    arith(k, szi, rnd(), rnd(), 1'(i), (i % 17) == 0);
            end
        end

        // R7 logic
        for (int i = 0; i < 200; i++) begin
            logic [31:0] nn;
            nn = (i % 10 == 0) ? 32'd0 : rnd();
            if (i == 1) nn = 32'h8000_0000;
            rec(4'd10, nn, rnd(), 32'hffff_ffff, nn[3], 1'b1);
            check("R7 logic flags", 32'(flags_o), 32'({nn[3], nn[31], nn == 0, 1'b0, 1'b0}));
            if (i % 20 == 0) flush_check("R7", {nn[3], nn[31], nn == 0, 1'b0, 1'b0});
        end

        // R8 load all flag bytes
        for (int f = 0; f < 32; f++) begin
            ccr_i = 5'(f);
            cmd_i = 2'd2;
            @(negedge clk);
            cmd_i = 2'd0;
            check("R8 load flags", 32'(flags_o), 32'(f));
            check("R8 load tag", 32'(tag_o), 32'd0);
            check("R8 n word", n_o, f[3] ? 32'hffff_ffff : 32'd0);
            check("R8 z word", z_o, f[2] ? 32'd0 : 32'd1);
            check("R8 v word", v_o, f[1] ? 32'hffff_ffff : 32'd0);
        end

        // R10 unknown tags
        rec(4'd3, 32'h0000_0001, 32'd0, 32'h0000_0002, 1'b1, 1'b0);
        prev = flags_o;
        prevtag = tag_o;
        for (int t = 11; t < 16; t++) begin
            rec(4'(t), rnd(), rnd(), rnd(), 1'b0, 1'b1);
            check("R10 err raised", 32'(err_o), 32'd1);
            check("R10 flags kept", 32'(flags_o), 32'(prev));
            check("R10 tag kept", 32'(tag_o), 32'(prevtag));
            @(negedge clk);
            check("R10 err drops", 32'(err_o), 32'd0);
        end

        // R11 idle holds state while data wiggles
        rec(4'd6, 32'h1234_5678, 32'd0, 32'h8765_4321, 1'b0, 1'b0);
        prev = flags_o;
        for (int i = 0; i < 20; i++) begin
            n_i = rnd(); v_i = rnd(); z_i = rnd(); tag_i = 4'(i); ccr_i = 5'(i);
            x_i = n_i[0]; c_i = v_i[0];
            @(negedge clk);
            check("R11 idle flags", 32'(flags_o), 32'(prev));
            check("R11 idle n", n_o, 32'h1234_5678);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule